// File: doc/BRIEF.md
# Dual Bus Port Selection Unit

This unit sits between a processor core and a system bus. Every bus request carries a 64-bit address plus an 8-bit port field that picks the target region. The unit holds two port registers. One steers instruction fetches and the other steers data loads and stores. For each request it forwards to the bus, it drives the port field from the register that matches the request kind. When the core fetches and accesses data in the same cycle, the unit arbitrates between the two requests. It also filters the responses that come back.

Software sets both registers by moving a value into a target register address, as a transport-triggered core does. It reads them back through a source register address so it can save and restore them. Writing the fetch port sends the core a one-cycle flush. The core then restarts fetching at address zero on the newly selected port. If a fetch was already in flight on the old port, its response is thrown away and is never delivered as an instruction.

Top module: `bus_port_sel`

## Requirements
- R1: After reset both port registers read back as 0x00, `pc_flush` is low, `bus_valid` is low while no request is present, and no instruction or data response is delivered.
- R2: With `mv_rd_sel` equal to `FETCH_SEL` (default 0x1E), `mv_rd_data` returns the fetch port. With `TXN_SEL` (default 0x1F) it returns the transaction port. Any other select returns zero.
- R3: A forwarded fetch drives `bus_is_data` = 0 and `bus_port` = fetch port. A forwarded load or store drives `bus_is_data` = 1 and `bus_port` = transaction port.
- R4: A write to the transaction port applies to data requests that start after the clock edge of the write. Fetches keep using the fetch port.
- R5: A write to the fetch port raises `pc_flush` for exactly the one cycle after the write edge. In that cycle no fetch is granted, and the core restarts fetching at address zero.
- R6: When a fetch and a data request are both present, the data request is forwarded and `f_gnt` stays low.
- R7: While a request waits for `bus_ready`, its `bus_port` value stays fixed, even if its port register is rewritten. A fetch cancelled by a flush is the exception.
- R8: At most one fetch is outstanding. Once a fetch is granted, no other fetch is granted until a fetch response (`rsp_valid` = 1, `rsp_is_data` = 0) returns.
- R9: A fetch response for a fetch granted before a fetch-port write is dropped (`core_ivalid` stays low). Later fetch responses are delivered.
- R10: A data response (`rsp_is_data` = 1) raises `core_dvalid` and passes `rsp_data` to `core_rdata`. `bus_we` and `bus_wdata` follow the granted data request.
- R11: A write to any select other than `FETCH_SEL` or `TXN_SEL` leaves both registers unchanged and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_wr_en | input | 1 | Move into a target register |
| mv_wr_sel | input | SEL_W | Target register address |
| mv_wr_data | input | PORT_W | Value moved |
| mv_rd_sel | input | SEL_W | Source register address |
| mv_rd_data | output | PORT_W | Read-back value |
| pc_flush | output | 1 | One-cycle fetch restart pulse to the core |
| f_req | input | 1 | Fetch request |
| f_addr | input | ADDR_W | Fetch address |
| f_gnt | output | 1 | Fetch accepted by the bus |
| d_req | input | 1 | Load/store request |
| d_we | input | 1 | Store when high |
| d_addr | input | ADDR_W | Data address |
| d_wdata | input | DATA_W | Store data |
| d_gnt | output | 1 | Data request accepted |
| bus_valid | output | 1 | Request on the bus |
| bus_addr | output | ADDR_W | Request address |
| bus_port | output | PORT_W | Port extension of the address |
| bus_we | output | 1 | Store flag |
| bus_wdata | output | DATA_W | Store data |
| bus_is_data | output | 1 | 1 for load/store, 0 for fetch |
| bus_ready | input | 1 | Bus accepts the request |
| rsp_valid | input | 1 | Response from the bus |
| rsp_is_data | input | 1 | Response belongs to a load/store |
| rsp_data | input | DATA_W | Response data |
| core_ivalid | output | 1 | Instruction delivered to the core |
| core_dvalid | output | 1 | Load data delivered to the core |
| core_rdata | output | DATA_W | Response data to the core |

## Verification
The bench uses the default parameters: 64-bit addresses and data, an 8-bit port, and selects 0x1E and 0x1F. With these values it can drive port codes such as 0x42, 0x55 and 0x07, which differ in both nibbles, so a port taken from the wrong register shows up. It also writes through an unused select, 0x05. The vector walk steps through the interleavings of fetch and data traffic that matter most. These are a transaction write with a data request in the same cycle, a fetch that collides with a data request, and a fetch that is in flight when the fetch port is rewritten. Directed cases then stall the bus to show that a waiting request keeps its port while the register changes underneath it.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic {
    SRC_FETCH = 1'b0,
    SRC_DATA  = 1'b1
  } bus_src_e;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_FETCH = 0;
  localparam int unsigned CH_DATA  = 1;
endpackage

// File: rtl/bps_port_regs.sv
module bps_port_regs #(
  parameter int unsigned SEL_W     = 8,
  parameter int unsigned PORT_W    = 8,
  parameter logic [SEL_W-1:0] FETCH_SEL = 'h1E,
  parameter logic [SEL_W-1:0] TXN_SEL   = 'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] fetch_port,
  output logic [PORT_W-1:0] txn_port,
  output logic              wr_fetch,
  output logic              flush
);
  logic [PORT_W-1:0] fport_q, fport_d;
  logic [PORT_W-1:0] tport_q, tport_d;
  logic              flush_q, flush_d;
  logic              wr_txn;

  assign wr_fetch = wr_en && (wr_sel == FETCH_SEL);
  assign wr_txn   = wr_en && (wr_sel == TXN_SEL);

  always_comb begin
    fport_d = fport_q;
    tport_d = tport_q;
    if (wr_fetch) fport_d = wr_data;
    if (wr_txn)   tport_d = wr_data;
    flush_d = wr_fetch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fport_q <= '0;
      tport_q <= '0;
      flush_q <= 1'b0;
    end else begin
      if (wr_fetch) fport_q <= fport_d;
      if (wr_txn)   tport_q <= tport_d;
      flush_q <= flush_d;
    end
  end

  always_comb begin
    if (rd_sel == FETCH_SEL)    rd_data = fport_q;
    else if (rd_sel == TXN_SEL) rd_data = tport_q;
    else                        rd_data = '0;
  end

  assign fetch_port = fport_q;
  assign txn_port   = tport_q;
  assign flush      = flush_q;

  // R5: a flush pulse only follows a fetch-port write
  p_flush_after_write_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(wr_fetch));

  // R11: a move to an unrelated select leaves both registers alone
  p_foreign_sel_ignored_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != FETCH_SEL && wr_sel != TXN_SEL)
      |=> ($stable(fport_q) && $stable(tport_q)));
endmodule

// File: rtl/bps_req_chan.sv
module bps_req_chan #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              gnt,
  input  logic              cancel,
  input  logic [PORT_W-1:0] cur_port,
  output logic [PORT_W-1:0] port_out
);
  logic              busy_q, busy_d;
  logic [PORT_W-1:0] held_q;
  logic              capture;

  assign busy_d  = req && !gnt && !cancel;
  assign capture = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (capture) held_q <= cur_port;
    end
  end

  assign port_out = busy_q ? held_q : cur_port;

  // R7: a waiting request presents the same port until it is taken
  p_wait_port_stable_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt && !cancel) |=> (!req || $stable(port_out)));
endmodule

// File: rtl/bps_arb.sv
module bps_arb
  import bps_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              f_ok,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [PORT_W-1:0] f_port,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  input  logic [PORT_W-1:0] d_port,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [PORT_W-1:0] bus_port,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_is_data,
  output logic              f_gnt,
  output logic              d_gnt
);
  bus_src_e src;

  always_comb begin
    src       = d_req ? SRC_DATA : SRC_FETCH;
    bus_valid = d_req || f_ok;
    if (src == SRC_DATA) begin
      bus_addr  = d_addr;
      bus_port  = d_port;
      bus_we    = d_we;
      bus_wdata = d_wdata;
    end else begin
      bus_addr  = f_addr;
      bus_port  = f_port;
      bus_we    = 1'b0;
      bus_wdata = '0;
    end
    bus_is_data = (src == SRC_DATA);
    d_gnt       = d_req && bus_ready;
    f_gnt       = f_ok && !d_req && bus_ready;
  end

  // R6: a collision always goes to the data side
  p_data_first_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && f_ok) |-> (!f_gnt && bus_is_data));

  // R3: a fetch never carries the store flag
  p_fetch_no_store_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_is_data) |-> !bus_we);
endmodule

// File: rtl/bps_rsp_filter.sv
module bps_rsp_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic f_gnt,
  input  logic wr_fetch,
  input  logic rsp_valid,
  input  logic rsp_is_data,
  output logic f_out,
  output logic ival,
  output logic dval
);
  logic f_out_q, f_out_d;
  logic stale_q, stale_d;
  logic rsp_f;

  assign rsp_f = rsp_valid && !rsp_is_data;

  always_comb begin
    f_out_d = f_gnt || (f_out_q && !rsp_f);
    if (wr_fetch)   stale_d = (f_out_q && !rsp_f) || f_gnt;
    else if (rsp_f) stale_d = 1'b0;
    else            stale_d = stale_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_out_q <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      f_out_q <= f_out_d;
      stale_q <= stale_d;
    end
  end

  assign f_out = f_out_q;
  assign ival  = rsp_f && !stale_q;
  assign dval  = rsp_valid && rsp_is_data;

  // R8: no second fetch while one is in flight
  p_single_fetch_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    f_out_q |-> !f_gnt);

  // R9: a fetch from the old port is never handed to the core
  p_stale_dropped_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> !ival);
endmodule

// File: rtl/bus_port_sel.sv
module bus_port_sel
  import bps_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned SEL_W  = 8,
  parameter logic [SEL_W-1:0] FETCH_SEL = 'h1E,
  parameter logic [SEL_W-1:0] TXN_SEL   = 'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_wr_en,
  input  logic [SEL_W-1:0]  mv_wr_sel,
  input  logic [PORT_W-1:0] mv_wr_data,
  input  logic [SEL_W-1:0]  mv_rd_sel,
  output logic [PORT_W-1:0] mv_rd_data,
  output logic              pc_flush,
  input  logic              f_req,
  input  logic [ADDR_W-1:0] f_addr,
  output logic              f_gnt,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic              d_gnt,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [PORT_W-1:0] bus_port,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_is_data,
  input  logic              bus_ready,
  input  logic              rsp_valid,
  input  logic              rsp_is_data,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              core_ivalid,
  output logic              core_dvalid,
  output logic [DATA_W-1:0] core_rdata
);
  logic [PORT_W-1:0] fetch_port, txn_port;
  logic              wr_fetch, flush, f_out, f_ok;
  logic [PORT_W-1:0] ch_cur  [NUM_CHAN];
  logic [PORT_W-1:0] ch_port [NUM_CHAN];
  logic              ch_req  [NUM_CHAN];
  logic              ch_gnt  [NUM_CHAN];
  logic              ch_can  [NUM_CHAN];

  bps_port_regs #(
    .SEL_W(SEL_W), .PORT_W(PORT_W), .FETCH_SEL(FETCH_SEL), .TXN_SEL(TXN_SEL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mv_wr_en), .wr_sel(mv_wr_sel), .wr_data(mv_wr_data),
    .rd_sel(mv_rd_sel), .rd_data(mv_rd_data),
    .fetch_port(fetch_port), .txn_port(txn_port),
    .wr_fetch(wr_fetch), .flush(flush)
  );

  assign f_ok = f_req && !flush && !f_out;

  assign ch_cur[CH_FETCH] = fetch_port;
  assign ch_req[CH_FETCH] = f_req;
  assign ch_gnt[CH_FETCH] = f_gnt;
  assign ch_can[CH_FETCH] = flush;
  assign ch_cur[CH_DATA]  = txn_port;
  assign ch_req[CH_DATA]  = d_req;
  assign ch_gnt[CH_DATA]  = d_gnt;
  assign ch_can[CH_DATA]  = 1'b0;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    bps_req_chan #(.PORT_W(PORT_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .req(ch_req[c]), .gnt(ch_gnt[c]), .cancel(ch_can[c]),
      .cur_port(ch_cur[c]), .port_out(ch_port[c])
    );
  end

  bps_arb #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .f_ok(f_ok), .f_addr(f_addr), .f_port(ch_port[CH_FETCH]),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_port(ch_port[CH_DATA]), .bus_ready(bus_ready),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_port(bus_port),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_is_data(bus_is_data),
    .f_gnt(f_gnt), .d_gnt(d_gnt)
  );

  bps_rsp_filter u_rsp (
    .clk(clk), .rst_n(rst_n),
    .f_gnt(f_gnt), .wr_fetch(wr_fetch),
    .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data),
    .f_out(f_out), .ival(core_ivalid), .dval(core_dvalid)
  );

  assign core_rdata = rsp_data;
  assign pc_flush   = flush;

  // R5: the restart cycle grants no fetch
  p_flush_blocks_fetch_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    pc_flush |-> !f_gnt);
endmodule

// File: tb/bus_port_sel_tb.sv
module bus_port_sel_tb;
  logic        clk, rst_n;
  logic        mv_wr_en;
  logic [7:0]  mv_wr_sel, mv_wr_data, mv_rd_sel, mv_rd_data;
  logic        pc_flush, f_req, f_gnt, d_req, d_we, d_gnt;
  logic [63:0] f_addr, d_addr, d_wdata, bus_addr, bus_wdata, rsp_data, core_rdata;
  logic        bus_valid, bus_we, bus_is_data, bus_ready;
  logic [7:0]  bus_port;
  logic        rsp_valid, rsp_is_data, core_ivalid, core_dvalid;
  int          n_chk, n_bad;
  logic        done;

  bus_port_sel u_dut (
    .clk(clk), .rst_n(rst_n),
    .mv_wr_en(mv_wr_en), .mv_wr_sel(mv_wr_sel), .mv_wr_data(mv_wr_data),
    .mv_rd_sel(mv_rd_sel), .mv_rd_data(mv_rd_data), .pc_flush(pc_flush),
    .f_req(f_req), .f_addr(f_addr), .f_gnt(f_gnt),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata), .d_gnt(d_gnt),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_port(bus_port),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_is_data(bus_is_data),
    .bus_ready(bus_ready), .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data),
    .rsp_data(rsp_data), .core_ivalid(core_ivalid), .core_dvalid(core_dvalid),
    .core_rdata(core_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Layout: wr_en | sel[8] | data[8] | f_req d_req rsp_v rsp_d |
  //         exp_valid exp_isdata | exp_port[8] | exp_fgnt exp_flush exp_ival
  localparam int NV = 11;
  localparam logic [33:0] TBL [NV] = '{
    {1'b0, 8'h00, 8'h00, 4'b1000, 2'b10, 8'h00, 3'b100},
    {1'b0, 8'h00, 8'h00, 4'b0010, 2'b00, 8'h00, 3'b001},
    {1'b1, 8'h1F, 8'h42, 4'b0100, 2'b11, 8'h00, 3'b000},
    {1'b0, 8'h00, 8'h00, 4'b1100, 2'b11, 8'h42, 3'b000},
    {1'b0, 8'h00, 8'h00, 4'b1000, 2'b10, 8'h00, 3'b100},
    {1'b0, 8'h00, 8'h00, 4'b0010, 2'b00, 8'h00, 3'b001},
    {1'b1, 8'h1E, 8'h07, 4'b1000, 2'b10, 8'h00, 3'b100},
    {1'b0, 8'h00, 8'h00, 4'b1000, 2'b00, 8'h00, 3'b010},
    {1'b0, 8'h00, 8'h00, 4'b0010, 2'b00, 8'h00, 3'b000},
    {1'b0, 8'h00, 8'h00, 4'b1000, 2'b10, 8'h07, 3'b100},
    {1'b0, 8'h00, 8'h00, 4'b0010, 2'b00, 8'h00, 3'b001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mv_wr_en = 0; mv_wr_sel = 0; mv_wr_data = 0;
    f_req = 0; d_req = 0; d_we = 0;
    rsp_valid = 0; rsp_is_data = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    done = 0; n_chk = 0; n_bad = 0;
    rst_n = 0; idle();
    mv_rd_sel = 8'h1E; f_addr = 0; d_addr = 64'h1000; d_wdata = 0;
    bus_ready = 1; rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #5;
    // R1 reset state
    chk("R1 fetch port", mv_rd_data, 8'h00);
    mv_rd_sel = 8'h1F; #1;
    chk("R1 txn port", mv_rd_data, 8'h00);
    chk("R1 flush", pc_flush, 0);
    chk("R1 bus idle", bus_valid, 0);
    chk("R1 no ivalid", core_ivalid, 0);
    chk("R1 no dvalid", core_dvalid, 0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      @(negedge clk);
      v = TBL[i];
      mv_wr_en = v[33]; mv_wr_sel = v[32:25]; mv_wr_data = v[24:17];
      f_req = v[16]; d_req = v[15]; rsp_valid = v[14]; rsp_is_data = v[13];
      #5;
      chk($sformatf("R3 valid v%0d", i), bus_valid, v[12]);
      if (v[12]) begin
        chk($sformatf("R3 kind v%0d", i), bus_is_data, v[11]);
        chk($sformatf("R4 port v%0d", i), bus_port, v[10:3]);
      end
      chk($sformatf("R6 fgnt v%0d", i), f_gnt, v[2]);
      chk($sformatf("R5 flush v%0d", i), pc_flush, v[1]);
      chk($sformatf("R9 ivalid v%0d", i), core_ivalid, v[0]);
    end

    // R2 read back of both registers and an unused select
    @(negedge clk); idle();
    mv_rd_sel = 8'h1E; #1; chk("R2 fetch read", mv_rd_data, 8'h07);
    mv_rd_sel = 8'h1F; #1; chk("R2 txn read", mv_rd_data, 8'h42);
    mv_rd_sel = 8'h20; #1; chk("R2 other read", mv_rd_data, 8'h00);

    // R7 waiting data request keeps its port across a txn write
    bus_ready = 0; d_req = 1; #4;
    chk("R7 first port", bus_port, 8'h42);
    chk("R7 no grant", d_gnt, 0);
    @(negedge clk); mv_wr_en = 1; mv_wr_sel = 8'h1F; mv_wr_data = 8'h55; #5;
    chk("R7 wait port a", bus_port, 8'h42);
    @(negedge clk); mv_wr_en = 0; #5;
    chk("R7 wait port b", bus_port, 8'h42);
    @(negedge clk); bus_ready = 1; #5;
    chk("R7 granted port", bus_port, 8'h42);
    chk("R7 granted", d_gnt, 1);
    @(negedge clk); d_req = 0; #5;
    @(negedge clk); d_req = 1; d_we = 1; d_wdata = 64'hCAFE; #5;
    chk("R4 new request port", bus_port, 8'h55);
    chk("R10 store flag", bus_we, 1);
    chk("R10 store data", bus_wdata, 64'hCAFE);

    // R10 data response delivery
    @(negedge clk); idle(); rsp_valid = 1; rsp_is_data = 1; rsp_data = 64'hDEAD; #5;
    chk("R10 dvalid", core_dvalid, 1);
    chk("R10 rdata", core_rdata, 64'hDEAD);
    chk("R10 no ivalid", core_ivalid, 0);

    // R8 single outstanding fetch
    @(negedge clk); idle(); f_req = 1; #5;
    chk("R8 first grant", f_gnt, 1);
    @(negedge clk); #5;
    chk("R8 second blocked", f_gnt, 0);
    chk("R8 bus idle", bus_valid, 0);
    @(negedge clk); f_req = 0; rsp_valid = 1; #5;
    chk("R9 normal delivery", core_ivalid, 1);
    @(negedge clk); idle(); f_req = 1; #5;
    chk("R8 grant after rsp", f_gnt, 1);

    // R11 unused select write ignored
    @(negedge clk); idle(); rsp_valid = 1;
    mv_wr_en = 1; mv_wr_sel = 8'h05; mv_wr_data = 8'hAA; #5;
    @(negedge clk); idle(); #5;
    chk("R11 no flush", pc_flush, 0);
    mv_rd_sel = 8'h1E; #1; chk("R11 fetch kept", mv_rd_data, 8'h07);
    mv_rd_sel = 8'h1F; #1; chk("R11 txn kept", mv_rd_data, 8'h55);

    // R5 flush lasts one cycle
    @(negedge clk); mv_wr_en = 1; mv_wr_sel = 8'h1E; mv_wr_data = 8'h3C; #5;
    @(negedge clk); idle(); f_req = 1; f_addr = 0; #5;
    chk("R5 flush high", pc_flush, 1);
    chk("R5 fetch held", f_gnt, 0);
    @(negedge clk); #5;
    chk("R5 flush low", pc_flush, 0);
    chk("R5 restart port", bus_port, 8'h3C);
    chk("R5 restart addr", bus_addr, 64'h0);

    @(negedge clk); idle();
    done = 1;
    finish_run();
  end
endmodule